// File: doc/BRIEF.md
# Counter-to-Float Compression Encoder

This block squeezes a wide unsigned timer count into a 16-bit word that keeps full precision for small counts and relative precision for large ones. The upper nibble of the result is an exponent. The lower twelve bits hold a mantissa. Counts that fit in twelve bits pass through unchanged with exponent zero. Larger counts are reduced by locating their most significant set bit and keeping a twelve-bit window that starts at that bit. The window keeps the leading one, so the result is a segmented, log-like companding and not a normalised hidden-bit format.

A conversion happens when a calculate strobe goes from low to high. The strobe is sampled in the block's clock domain. On the clock edge that first sees the strobe high, the encoder registers the compressed form of the count present on its input. A one-cycle valid pulse marks each new result. Between conversions the output keeps its value, whatever the input does. Bits below the kept window are discarded without rounding, so a decoded result is never larger than the original count.

Top module: `cnt_float_enc`

## Requirements
- R1: The output word carries the exponent in bits 15..12 and the mantissa in bits 11..0. Any input below 4096 is encoded with exponent 0 and a mantissa equal to the input, for example 4095 gives 16'h0FFF.
- R2: For an input whose highest set bit is k, with 12 <= k <= 26, the exponent is k-11 and the mantissa is input bits k down to k-11. For example 4096 gives 16'h1800. Every nonzero exponent therefore comes with mantissa bit 11 set.
- R3: An input with bit 26 set encodes with exponent 15 and mantissa equal to input bits 26..15. For example 2^27-1 gives 16'hFFFF.
- R4: Discarded low bits are truncated. With decoded value D = mantissa << exponent, D never exceeds the input, and input minus D is below 2^exponent.
- R5: An input of zero encodes to 16'h0000.
- R6: A conversion is taken on the first rising clock edge at which calcStrobe is high after it was low at the previous edge. The new result is visible after that edge.
- R7: When no conversion is taken, the output holds its value. Changes on countIn with calcStrobe low have no effect, and neither do changes while calcStrobe stays high.
- R8: floatValid is high for exactly one clock cycle after each conversion and low otherwise.
- R9: A synchronous reset clears floatOut to zero and floatValid to low, and makes calcStrobe count as low at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| calcStrobe | input | 1 | Calculate request; its low-to-high transition starts a conversion |
| countIn | input | 27 | Unsigned count to compress |
| floatOut | output | 16 | Compressed result: exponent in 15..12, mantissa in 11..0 |
| floatValid | output | 1 | One-cycle pulse after each conversion |

## Verification
The bench targets the seams between segments: 4095 against 4096, each single power of two from bit 12 to bit 26, and all-ones patterns. An off-by-one in the leading-one search or the shifter would shift the mantissa window by one bit at exactly these points, and the decoded error would then exceed its bound. Zero and the all-ones input catch an encoder that gives an empty search a nonzero exponent, or that mishandles the top bit. A strobe held high while the input changes, and input changes made with the strobe low, catch a design that captures on a level instead of an edge, or whose valid pulse runs longer than one cycle.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic load;   // take a new conversion this edge
    logic clear;  // synchronous clear of the result register
  } cfe_strobe_t;

endpackage

// File: rtl/cfe_lead_one.sv
// Priority search over the count bits above the linear range.
// Returns the right-shift amount: 0 when none of those bits is set,
// otherwise (position of highest set bit within the upper field) + 1.
module cfe_lead_one #(
  parameter int HI_W    = 15,
  parameter int SHIFT_W = 4
) (
  input  logic [HI_W-1:0]    upperBits,
  output logic [SHIFT_W-1:0] shiftAmt
);

  always_comb begin
    shiftAmt = '0;
    for (int i = 0; i < HI_W; i++) begin
      if (upperBits[i]) shiftAmt = SHIFT_W'(i + 1);
    end
  end

endmodule

// File: rtl/cfe_shifter.sv
// Logarithmic right shifter: one stage per bit of the shift amount.
module cfe_shifter #(
  parameter int IN_W    = 27,
  parameter int MANT_W  = 12,
  parameter int SHIFT_W = 4
) (
  input  logic [IN_W-1:0]    value,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [MANT_W-1:0]  mantissa
);

  logic [IN_W-1:0] stage [SHIFT_W+1];

  assign stage[0] = value;

  for (genvar g = 0; g < SHIFT_W; g++) begin : g_stage
    localparam int STEP = 1 << g;
    assign stage[g+1] = shiftAmt[g] ? (stage[g] >> STEP) : stage[g];
  end

  assign mantissa = stage[SHIFT_W][MANT_W-1:0];

endmodule

// File: rtl/cfe_ctrl.sv
// Samples the calculate strobe, detects its low-to-high transition,
// and produces the load/clear strobes plus the valid pulse.
module cfe_ctrl
  import cfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        calcStrobe,
  output cfe_strobe_t ctl,
  output logic        floatValid
);

  logic calcPrev;
  logic calcEdge;

  assign calcEdge  = calcStrobe & ~calcPrev;
  assign ctl.load  = calcEdge;
  assign ctl.clear = rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      calcPrev   <= 1'b0;
      floatValid <= 1'b0;
    end else begin
      calcPrev   <= calcStrobe;
      floatValid <= calcEdge;
    end
  end

endmodule

// File: rtl/cfe_datapath.sv
// Leading-one search, barrel shift and result register.
module cfe_datapath
  import cfe_pkg::*;
#(
  parameter int IN_W   = 27,
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic                    clk,
  input  cfe_strobe_t             ctl,
  input  logic [IN_W-1:0]         countIn,
  output logic [EXP_W+MANT_W-1:0] floatOut
);

  localparam int HI_W    = IN_W - MANT_W;
  localparam int SHIFT_W = $clog2(HI_W + 1);
  localparam int OUT_W   = EXP_W + MANT_W;

  logic [SHIFT_W-1:0] shiftAmt;
  logic [MANT_W-1:0]  mantissa;
  logic [OUT_W-1:0]   packedWord;

  cfe_lead_one #(
    .HI_W    (HI_W),
    .SHIFT_W (SHIFT_W)
  ) u_lead (
    .upperBits (countIn[IN_W-1:MANT_W]),
    .shiftAmt  (shiftAmt)
  );

  cfe_shifter #(
    .IN_W    (IN_W),
    .MANT_W  (MANT_W),
    .SHIFT_W (SHIFT_W)
  ) u_shift (
    .value    (countIn),
    .shiftAmt (shiftAmt),
    .mantissa (mantissa)
  );

  assign packedWord = {EXP_W'(shiftAmt), mantissa};

  always_ff @(posedge clk) begin
    if (ctl.clear)     floatOut <= '0;
    else if (ctl.load) floatOut <= packedWord;
  end

endmodule

// File: rtl/cnt_float_enc.sv
// Counter-to-float compression encoder, top level.
module cnt_float_enc
  import cfe_pkg::*;
#(
  parameter int IN_W   = 27,
  parameter int MANT_W = 12,
  parameter int EXP_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    calcStrobe,
  input  logic [IN_W-1:0]         countIn,
  output logic [EXP_W+MANT_W-1:0] floatOut,
  output logic                    floatValid
);

  cfe_strobe_t ctl;

  cfe_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .calcStrobe (calcStrobe),
    .ctl        (ctl),
    .floatValid (floatValid)
  );

  cfe_datapath #(
    .IN_W   (IN_W),
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
  ) u_dp (
    .clk      (clk),
    .ctl      (ctl),
    .countIn  (countIn),
    .floatOut (floatOut)
  );

endmodule

// File: rtl/cnt_float_enc_checker.sv
module cnt_float_enc_checker #(
  parameter int MANT_W = 12,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             calcStrobe,
  input logic [OUT_W-1:0] floatOut,
  input logic             floatValid
);

  logic strobeQ;
  logic rstQ;

  always_ff @(posedge clk) begin
    rstQ    <= rst;
    strobeQ <= rst ? 1'b0 : calcStrobe;
  end

  // R6: a strobe transition yields a valid result on the next cycle
  a_r6_capture_edge: assert property (@(posedge clk) disable iff (rst)
    (calcStrobe && !strobeQ) |=> floatValid);

  // R8: valid never lasts two cycles, and never appears without a transition
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    floatValid |=> !floatValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(calcStrobe && !strobeQ) |=> !floatValid);

  // R7: without a fresh conversion the result holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!floatValid && !rstQ) |-> $stable(floatOut));

  // R2: a nonzero exponent always carries an explicit leading one
  a_r2_leading_one: assert property (@(posedge clk) disable iff (rst)
    (floatValid && floatOut[OUT_W-1:MANT_W] != '0) |-> floatOut[MANT_W-1]);

  // R5: an all-zero mantissa only occurs with exponent zero
  a_r5_zero_word: assert property (@(posedge clk) disable iff (rst)
    (floatValid && floatOut[MANT_W-1:0] == '0) |-> floatOut[OUT_W-1:MANT_W] == '0);

  // R9: the cycle after reset shows a cleared result and no valid
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    rstQ |-> (floatOut == '0 && !floatValid));

endmodule

bind cnt_float_enc cnt_float_enc_checker #(
  .MANT_W (MANT_W),
  .OUT_W  (EXP_W + MANT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .calcStrobe (calcStrobe),
  .floatOut   (floatOut),
  .floatValid (floatValid)
);

// File: tb/cnt_float_enc_test.sv
module cnt_float_enc_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        calcStrobe = 1'b0;
  logic [26:0] countIn = '0;
  logic [15:0] floatOut;
  logic        floatValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cnt_float_enc uut (
    .clk        (clk),
    .rst        (rst),
    .calcStrobe (calcStrobe),
    .countIn    (countIn),
    .floatOut   (floatOut),
    .floatValid (floatValid)
  );

  function automatic logic [15:0] refEnc(input logic [26:0] v);
    int top;
    logic [26:0] sh;
    top = -1;
    for (int i = 0; i < 27; i++) if (v[i]) top = i;
    if (top < 12) return {4'd0, v[11:0]};
    sh = v >> (top - 11);
    return {4'(top - 11), sh[11:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  // R4: truncation bound on the decoded value
  task automatic checkBound(input logic [26:0] v, input logic [15:0] w);
    logic [31:0] dec;
    logic [31:0] span;
    bit ok;
    dec  = 32'(w[11:0]) << w[15:12];
    span = 32'd1 << w[15:12];
    ok   = (dec <= 32'(v)) && ((32'(v) - dec) < span);
    check("R4 bound", {31'd0, ok}, 32'd1);
  endtask

  task automatic doConvert(input logic [26:0] v, input string req);
    logic [15:0] want;
    want = refEnc(v);
    @(negedge clk);
    countIn = v;
    calcStrobe = 1'b1;
    @(negedge clk);
    check({req, " result"}, {16'd0, floatOut}, {16'd0, want});
    check("R8 valid high", {31'd0, floatValid}, 32'd1);
    checkBound(v, floatOut);
    calcStrobe = 1'b0;
    countIn = ~v;  // R7: change with strobe low must not matter
    @(negedge clk);
    check("R8 valid low", {31'd0, floatValid}, 32'd0);
    check("R7 held", {16'd0, floatOut}, {16'd0, want});
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R9 reset out", {16'd0, floatOut}, 32'd0);
    check("R9 reset valid", {31'd0, floatValid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    doConvert(27'd0, "R5 zero");
    doConvert(27'd1, "R1 one");
    doConvert(27'd4095, "R1 top of linear");
    doConvert(27'd4096, "R2 first segment");
    check("R2 4096 word", {16'd0, floatOut}, 32'h1800);
    doConvert(27'h4000000, "R3 bit26 only");
    doConvert(27'h7FFFFFF, "R3 all ones");
    check("R3 all ones word", {16'd0, floatOut}, 32'hFFFF);
    for (int k = 12; k < 27; k++) begin
      doConvert(27'(1 << k), "R2 power of two");
      doConvert(27'((1 << (k + 1)) - 1), "R2 segment ones");
    end

    // R7: strobe held high while input changes does not recapture
    @(negedge clk);
    countIn = 27'h0123456;
    calcStrobe = 1'b1;
    @(negedge clk);
    check("R6 capture", {16'd0, floatOut}, {16'd0, refEnc(27'h0123456)});
    countIn = 27'h7000001;
    @(negedge clk);
    check("R7 level no recapture", {16'd0, floatOut}, {16'd0, refEnc(27'h0123456)});
    check("R8 no repeat valid", {31'd0, floatValid}, 32'd0);
    countIn = 27'h0000055;
    @(negedge clk);
    check("R7 still held", {16'd0, floatOut}, {16'd0, refEnc(27'h0123456)});
    calcStrobe = 1'b0;
    @(negedge clk);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      int width;
      width = int'($urandom % 27) + 1;
      r = $urandom & ((32'd1 << width) - 1);
      doConvert(r[26:0], "R2 random");
    end

    // R9: reset mid-run clears the result
    doConvert(27'h3ABCDEF, "R2 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid reset out", {16'd0, floatOut}, 32'd0);
    check("R9 mid reset valid", {31'd0, floatValid}, 32'd0);
    rst = 1'b0;
    doConvert(27'd2048, "R1 after reset");

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule